// File: doc/BRIEF.md
# Ethernet Receive Frame Queue

This block buffers received Ethernet frames for a processor that fetches them through a single 32-bit data port. Frames arrive as a byte stream with a valid strobe and an end-of-frame marker. Each frame is accepted only when the receive enable is high and a free slot exists. The block stores it in one slot of a circular queue together with a computed trailer and a length header. The processor learns how many frames are waiting from a pending count. It then issues read requests, each of which returns the next four stored bytes, packed little-endian.

A stored frame image is laid out as follows. The first two bytes hold a length equal to the frame size plus 6, low byte first. The frame bytes follow in arrival order, then the four CRC-32 bytes, least significant first. Any leftover bytes of the final 32-bit word read as zero. When the last word of an image has been read, the queue moves to the next slot by itself. A flush input empties the queue, abandons a partly read image and abandons any frame still being stored. Each stored frame produces a one-cycle receive event for the interrupt logic.

The slot count and the slot size are parameters. The slot size defaults to 256 bytes and can be raised to 2048. The largest frame that is accepted is the slot size minus 6 bytes.

Top module: `eth_rxq`

## Requirements
- R1: The queue has SLOTS (default 31) frame slots used circularly; `pending` gives the number of stored frames not yet fully read and never exceeds SLOTS.
- R2: A frame whose first byte arrives while `rx_en` is low, or while `pending` equals SLOTS, is discarded entirely: `pending` does not change and no stored image is altered.
- R3: A stored image begins with a 16-bit length equal to frame size plus 6, in bits 7:0 (low byte) and 15:8 (high byte) of the first word. The frame bytes follow in arrival order, from bit 23:16 of the first word onward.
- R4: The four bytes after the frame bytes hold the CRC-32 of the frame bytes, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end.
- R5: Bytes of the final word that lie beyond the image length read as zero.
- R6: Each stored frame gives exactly one single-cycle `rx_event` pulse, in the cycle in which `pending` first shows the increment.
- R7: A one-cycle `rd_req` loads `rd_data` at the next clock edge with the next stored word, little-endian. The read that returns the final word of an image (read number ceil(length/4)) moves the queue to the next slot, modulo SLOTS, and decrements `pending`.
- R8: A read request while `pending` is zero returns zero and leaves `pending` at zero.
- R9: A `flush` pulse sets `pending` to zero, discards a partly read image and abandons a frame being stored; the next frame stored is read from its first word.
- R10: A frame longer than SLOT_BYTES-6 bytes is dropped without changing `pending`; a frame of exactly SLOT_BYTES-6 bytes is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled at the first byte of a frame |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| flush | input | 1 | Empties the queue |
| rd_req | input | 1 | Read-request pulse for the data port |
| rd_data | output | 32 | Word returned by the last read request |
| pending | output | $clog2(SLOTS+1) | Number of frames waiting |
| rx_event | output | 1 | One-cycle pulse per stored frame |

## Verification
The assertions assume that `rd_req` and `flush` are single-cycle pulses driven from the register interface. They also assume at least six idle cycles follow the last byte of a frame, because the trailer and header are written during those cycles. The bench keeps to both assumptions. Every frame task drives one byte per cycle, then waits seven idle cycles. Reads and flushes are issued as isolated one-cycle pulses, never while a frame is on the input.

// File: rtl/eth_rxq_pkg.sv
package eth_rxq_pkg;

  typedef enum logic [2:0] {
    W_IDLE,
    W_DATA,
    W_TRAIL,
    W_HDR,
    W_SKIP
  } wr_state_e;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  // One byte of a reflected CRC-32 update
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'b0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_rxq_slot_mem.sv
module eth_rxq_slot_mem #(
  parameter int DEPTH = 1984,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [3:0]    wmask,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem_q [DEPTH];

  for (genvar ln = 0; ln < 4; ln++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && wmask[ln]) begin
        mem_q[waddr][8*ln +: 8] <= wdata[8*ln +: 8];
      end
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/eth_rxq_writer.sv
module eth_rxq_writer
  import eth_rxq_pkg::*;
#(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 256,
  parameter int SW         = $clog2(SLOTS),
  parameter int CW         = $clog2(SLOTS + 1),
  parameter int PW         = $clog2(SLOT_BYTES + 1),
  parameter int AW         = $clog2(SLOTS * (SLOT_BYTES / 4))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          flush,
  input  logic [SW-1:0] head,
  input  logic [CW-1:0] pending,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_mask,
  output logic [31:0]   mem_wdata,
  output logic          commit,
  output logic [SW-1:0] len_slot,
  output logic [PW-1:0] len_val,
  output logic          rx_event
);
  localparam int WPS = SLOT_BYTES / 4;
  localparam int TW  = CW + 1;
  localparam logic [AW-1:0] WPS_A     = AW'(WPS);
  localparam logic [PW-1:0] POS_FIRST = PW'(2);
  localparam logic [PW-1:0] POS_LIMIT = PW'(SLOT_BYTES - 4);

  wr_state_e     state_q, state_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [31:0]   crc_q, crc_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          event_q;

  logic          put, hdr;
  logic [7:0]    put_byte;
  logic [PW-1:0] put_pos;
  logic [SW-1:0] put_slot;
  logic [TW-1:0] tail_sum;
  logic [SW-1:0] tail_now;
  logic          room;
  logic [31:0]   crc_fin;
  logic [1:0]    lane;

  assign tail_sum = TW'(head) + TW'(pending);
  assign tail_now = (tail_sum >= TW'(SLOTS)) ? SW'(tail_sum - TW'(SLOTS)) : SW'(tail_sum);
  assign room     = (pending < CW'(SLOTS));
  assign crc_fin  = ~crc_q;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    pos_d    = pos_q;
    slot_d   = slot_q;
    crc_d    = crc_q;
    cnt_d    = cnt_q;
    put      = 1'b0;
    hdr      = 1'b0;
    commit   = 1'b0;
    put_byte = in_data;
    put_pos  = pos_q;
    put_slot = slot_q;
    unique case (state_q)
      W_IDLE: begin
        if (in_valid) begin
          if (!flush && rx_en && room) begin
            put      = 1'b1;
            put_pos  = POS_FIRST;
            put_slot = tail_now;
            slot_d   = tail_now;
            pos_d    = POS_FIRST + PW'(1);
            crc_d    = crc32_step(32'hFFFF_FFFF, in_data);
            cnt_d    = 2'd0;
            state_d  = in_last ? W_TRAIL : W_DATA;
          end else begin
            state_d  = in_last ? W_IDLE : W_SKIP;
          end
        end
      end
      W_DATA: begin
        if (flush) begin
          state_d = (in_valid && in_last) ? W_IDLE : W_SKIP;
        end else if (in_valid) begin
          if (pos_q >= POS_LIMIT) begin
            // too long for a slot: abandon without writing past the slot
            state_d = in_last ? W_IDLE : W_SKIP;
          end else begin
            put   = 1'b1;
            pos_d = pos_q + PW'(1);
            crc_d = crc32_step(crc_q, in_data);
            if (in_last) begin
              cnt_d   = 2'd0;
              state_d = W_TRAIL;
            end
          end
        end
      end
      W_TRAIL: begin
        if (flush) begin
          state_d = W_IDLE;
        end else begin
          put      = 1'b1;
          put_byte = crc_fin[8*cnt_q +: 8];
          pos_d    = pos_q + PW'(1);
          cnt_d    = cnt_q + 2'd1;
          if (cnt_q == 2'd3) state_d = W_HDR;
        end
      end
      W_HDR: begin
        state_d = W_IDLE;
        if (!flush) begin
          hdr    = 1'b1;
          commit = 1'b1;
        end
      end
      W_SKIP: begin
        if (in_valid && in_last) state_d = W_IDLE;
      end
      default: state_d = W_IDLE;
    endcase
  end

  // Memory write port: a byte starting a word clears its other lanes
  assign lane = put_pos[1:0];
  always_comb begin
    mem_we    = put | hdr;
    mem_addr  = AW'(put_slot) * WPS_A + AW'(put_pos >> 2);
    mem_mask  = 4'b0001 << lane;
    mem_wdata = {24'b0, put_byte} << {lane, 3'b000};
    if (put && (lane == 2'd0 || put_pos == POS_FIRST)) begin
      mem_mask = 4'b1111;
    end
    if (hdr) begin
      mem_addr  = AW'(slot_q) * WPS_A;
      mem_mask  = 4'b0011;
      mem_wdata = {16'b0, 16'(pos_q)};
    end
  end

  assign len_slot = slot_q;
  assign len_val  = pos_q;
  assign rx_event = event_q;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      pos_q   <= '0;
      slot_q  <= '0;
      crc_q   <= '0;
      cnt_q   <= '0;
      event_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      slot_q  <= slot_d;
      crc_q   <= crc_d;
      cnt_q   <= cnt_d;
      event_q <= commit;
    end
  end

endmodule

// File: rtl/eth_rxq_reader.sv
module eth_rxq_reader #(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 256,
  parameter int SW         = $clog2(SLOTS),
  parameter int CW         = $clog2(SLOTS + 1),
  parameter int PW         = $clog2(SLOT_BYTES + 1),
  parameter int AW         = $clog2(SLOTS * (SLOT_BYTES / 4))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          flush,
  input  logic          commit,
  input  logic [SW-1:0] len_slot,
  input  logic [PW-1:0] len_val,
  input  logic [31:0]   mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic [SW-1:0] head,
  output logic [CW-1:0] pending,
  output logic [31:0]   rd_data
);
  localparam int WPS = SLOT_BYTES / 4;
  localparam int WW  = $clog2(WPS);
  localparam logic [AW-1:0] WPS_A = AW'(WPS);

  logic [PW-1:0] len_mem [SLOTS];
  logic [SW-1:0] head_q, head_d;
  logic [CW-1:0] pend_q, pend_d;
  logic [WW-1:0] word_q, word_d;
  logic [31:0]   data_q, data_d;
  logic [PW-1:0] cur_len, last_full;
  logic [WW-1:0] last_word;
  logic          have, pop;

  assign cur_len   = len_mem[head_q];
  assign last_full = (cur_len - PW'(1)) >> 2;
  assign last_word = last_full[WW-1:0];
  assign mem_raddr = AW'(head_q) * WPS_A + AW'(word_q);
  assign have      = (pend_q != '0);
  assign pop       = rd_req && have && !flush && (word_q == last_word);

  // Next-state logic
  always_comb begin
    head_d = head_q;
    word_d = word_q;
    data_d = data_q;
    pend_d = pend_q + CW'(commit) - CW'(pop);
    if (flush) begin
      pend_d = '0;
      word_d = '0;
      if (rd_req) data_d = '0;
    end else if (rd_req) begin
      if (have) begin
        data_d = mem_rdata;
        word_d = pop ? '0 : word_q + WW'(1);
        if (pop) head_d = (head_q == SW'(SLOTS - 1)) ? '0 : head_q + SW'(1);
      end else begin
        data_d = '0;
      end
    end
  end

  // Frame length per slot, written when a frame is committed
  always_ff @(posedge clk) begin
    if (commit) len_mem[len_slot] <= len_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      pend_q <= '0;
      word_q <= '0;
      data_q <= '0;
    end else begin
      head_q <= head_d;
      pend_q <= pend_d;
      word_q <= word_d;
      data_q <= data_d;
    end
  end

  assign head    = head_q;
  assign pending = pend_q;
  assign rd_data = data_q;

endmodule

// File: rtl/eth_rxq.sv
module eth_rxq #(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 256,
  localparam int CW        = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          flush,
  input  logic          rd_req,
  output logic [31:0]   rd_data,
  output logic [CW-1:0] pending,
  output logic          rx_event
);
  localparam int WPS   = SLOT_BYTES / 4;
  localparam int DEPTH = SLOTS * WPS;
  localparam int SW    = $clog2(SLOTS);
  localparam int PW    = $clog2(SLOT_BYTES + 1);
  localparam int AW    = $clog2(DEPTH);

  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [3:0]    mem_mask;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          commit;
  logic [SW-1:0] len_slot, head;
  logic [PW-1:0] len_val;

  eth_rxq_writer #(
    .SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .SW(SW), .CW(CW), .PW(PW), .AW(AW)
  ) writer_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .flush(flush), .head(head), .pending(pending),
    .mem_we(mem_we), .mem_addr(mem_waddr), .mem_mask(mem_mask), .mem_wdata(mem_wdata),
    .commit(commit), .len_slot(len_slot), .len_val(len_val), .rx_event(rx_event)
  );

  eth_rxq_slot_mem #(.DEPTH(DEPTH), .AW(AW)) mem_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wmask(mem_mask), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  eth_rxq_reader #(
    .SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .SW(SW), .CW(CW), .PW(PW), .AW(AW)
  ) reader_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .flush(flush), .commit(commit),
    .len_slot(len_slot), .len_val(len_val), .mem_rdata(mem_rdata),
    .mem_raddr(mem_raddr), .head(head), .pending(pending), .rd_data(rd_data)
  );

endmodule

// File: rtl/eth_rxq_checker.sv
module eth_rxq_checker #(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 256,
  localparam int CW        = $clog2(SLOTS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          in_valid,
  input logic [7:0]    in_data,
  input logic          in_last,
  input logic          flush,
  input logic          rd_req,
  input logic [31:0]   rd_data,
  input logic [CW-1:0] pending,
  input logic          rx_event
);
  // R1: count bounded by the slot count
  a_r1_pending_max: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= CW'(SLOTS));

  // R8: empty read yields zero and keeps the queue empty
  a_r8_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && pending == '0) |=> (rd_data == 32'b0));

  // R9: flush empties the queue
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pending == '0));

  // R6: event coincides with the increment of the count
  a_r6_event_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_event && !$past(rd_req) && !$past(flush)) |-> (pending == $past(pending) + CW'(1)));

  // R7: the count only moves on a read, a flush or a stored frame
  a_r7_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_req && !flush) |=> (rx_event || $stable(pending)));

  // R6: the event is a single-cycle pulse
  a_r6_event_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |=> !rx_event);

endmodule

bind eth_rxq eth_rxq_checker #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) chk_i (.*);

// File: tb/eth_rxq_tb_top.sv
`timescale 1ns/1ps
module eth_rxq_tb_top;
  localparam int SLOTS      = 31;
  localparam int SLOT_BYTES = 256;
  localparam int CW         = $clog2(SLOTS + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_last = 1'b0;
  logic          flush = 1'b0;
  logic          rd_req = 1'b0;
  logic [31:0]   rd_data;
  logic [CW-1:0] pending;
  logic          rx_event;

  int checks = 0;
  int errors = 0;
  int events = 0;
  int stored = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];   // expected words, all frames in order
  int          nwords_q[$]; // words per expected frame

  always #5 clk = ~clk;

  eth_rxq #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) dut_i (.*);

  always @(posedge clk) if (rst_n && rx_event) events++;

  function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (b[i]) begin
      c ^= {24'b0, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [7:0] pat(input int id, input int i);
    return 8'((id * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: send one frame and, if it should be kept, push its image
  task automatic send_frame(input int id, input int size, input bit keep);
    logic [7:0] b[$];
    logic [7:0] img[$];
    logic [31:0] c;
    int len;
    for (int i = 0; i < size; i++) b.push_back(pat(id, i));
    for (int i = 0; i < size; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = b[i]; in_last = (i == size - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (7) @(negedge clk);
    if (keep) begin
      len = size + 6;
      c = ref_crc(b);
      img.push_back(8'(len)); img.push_back(8'(len >> 8));
      foreach (b[i]) img.push_back(b[i]);
      for (int k = 0; k < 4; k++) img.push_back(c[8*k +: 8]);
      while (img.size() % 4 != 0) img.push_back(8'h00);
      for (int w = 0; w < img.size() / 4; w++)
        exp_q.push_back({img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]});
      nwords_q.push_back(img.size() / 4);
      stored++;
    end
  endtask

  task automatic read_word(output logic [31:0] v);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    v = rd_data;
  endtask

  // Monitor side: read one frame and compare with the scoreboard
  task automatic drain_one(input string req);
    logic [31:0] v, e;
    int n = nwords_q.pop_front();
    for (int w = 0; w < n; w++) begin
      read_word(v);
      e = exp_q.pop_front();
      check(v === e, req, v, e);
    end
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1, R6, R7)
    check(pending == '0, "R1 reset pending", 32'(pending), 0);
    check(rd_data == '0, "R7 reset rd_data", rd_data, 0);
    check(events == 0, "R6 no event at reset", 32'(events), 0);

    // R8: underflow
    read_word(v);
    check(v == 32'b0, "R8 underflow data", v, 0);
    check(pending == '0, "R8 underflow pending", 32'(pending), 0);

    // R2: receive disabled
    send_frame(1, 9, 1'b0);
    check(pending == '0, "R2 disabled frame ignored", 32'(pending), 0);
    read_word(v);
    check(v == 32'b0, "R2 nothing stored", v, 0);

    // R3 R4 R5 R7: several sizes, each residue mod 4
    rx_en = 1'b1;
    send_frame(2, 1, 1'b1);
    send_frame(3, 2, 1'b1);
    send_frame(4, 3, 1'b1);
    send_frame(5, 4, 1'b1);
    send_frame(6, 60, 1'b1);
    check(pending == CW'(5), "R1 pending after five", 32'(pending), 5);
    check(events == 5, "R6 one event per frame", 32'(events), 5);
    drain_one("R3 R4 R5 size1");
    check(pending == CW'(4), "R7 pop after last word", 32'(pending), 4);
    drain_one("R3 R4 R5 size2");
    drain_one("R3 R4 R5 size3");
    drain_one("R4 R5 size4");
    drain_one("R3 R4 size60");
    check(pending == '0, "R7 all drained", 32'(pending), 0);

    // R10: slot-size boundary
    send_frame(7, SLOT_BYTES - 5, 1'b0);
    check(pending == '0, "R10 oversize dropped", 32'(pending), 0);
    send_frame(8, SLOT_BYTES - 6, 1'b1);
    check(pending == CW'(1), "R10 max size stored", 32'(pending), 1);
    drain_one("R10 max size image");

    // R2: full queue drops the extra frame; wraps the slots (R1)
    for (int f = 0; f < SLOTS; f++) send_frame(20 + f, 5 + (f % 4), 1'b1);
    check(pending == CW'(SLOTS), "R1 queue full", 32'(pending), SLOTS);
    send_frame(90, 7, 1'b0);
    check(pending == CW'(SLOTS), "R2 full queue drop", 32'(pending), SLOTS);
    p0 = events;
    check(p0 == stored, "R6 events match stored", 32'(p0), 32'(stored));
    for (int f = 0; f < SLOTS; f++) drain_one("R1 R2 wrap drain");
    check(pending == '0, "R1 drained after wrap", 32'(pending), 0);

    // R9: flush during a partial read
    send_frame(40, 10, 1'b1);
    send_frame(41, 5, 1'b1);
    read_word(v);
    check(v === exp_q[0], "R9 first word before flush", v, exp_q[0]);
    pulse_flush();
    check(pending == '0, "R9 flush clears", 32'(pending), 0);
    exp_q.delete(); nwords_q.delete();
    read_word(v);
    check(v == 32'b0, "R9 nothing after flush", v, 0);
    send_frame(42, 3, 1'b1);
    check(pending == CW'(1), "R9 new frame after flush", 32'(pending), 1);
    drain_one("R9 restart at header");

    finish_run();
  end

endmodule